// File: doc/BRIEF.md
# Frame Descriptor Sequencer with Branch Override

This block loads per-channel frame descriptors for a display DMA engine with up to seven channels. When a frame begins, it clears the source-address register of every channel. It then walks the channels in ascending index order. For each enabled channel it chooses a descriptor address and reads a four-word descriptor from memory, one word per handshake beat. The four words fill that channel's next-pointer, source, frame-ID and command registers.

The descriptor address normally comes from the chained next pointer that the previous descriptor left behind. Software can override it once by writing a branch register with its active bit set. The sequencer then fetches from the branch address, clears the active bit and, if the branch's interrupt bit is set, pulses a branch event. A descriptor address that would read outside the valid memory window is not fetched. When a channel is left with a zero or out-of-window source address, it raises a bus-error event. A done pulse follows the last channel. The registers are read back through a combinational select port.

Top module: `fdesc_fetch`

## Requirements
- R1: After reset every channel register (next pointer, source, frame ID, command, branch) reads zero, and `mem_rd_valid`, `branch_evt`, `berr_evt` and `done` are low.
- R2: A write with `wr_branch`=0 stores `wr_data & 0xFFFFFFF0` as the channel's next-descriptor pointer (`rd_sel`=0).
- R3: A write with `wr_branch`=1 stores `wr_data & 0xFFFFFFF3` as the channel's branch register (`rd_sel`=4). In that register bit 0 is branch-active, bit 1 is branch-interrupt and bits 31:4 are the branch address.
- R4: A fetch reads the words at A, A+4, A+8 and A+12, where A is the chosen address with its low four bits forced to zero. The words load, in that order, the next pointer (`rd_sel`=0), source (1), frame ID (2) and command (3). When no branch is active, A is the stored next pointer, so descriptors chain from frame to frame.
- R5: When branch-active is set, the fetch uses the branch address. Branch-active is cleared and all other branch bits are kept. `branch_evt` pulses once with `evt_ch` equal to the channel if and only if branch-interrupt is set.
- R6: A frame start clears the source register of every channel. A channel whose `ch_en` bit is low is not fetched, raises no event, and keeps its other registers.
- R7: A descriptor address A is fetched only when BASE <= A and A+16 <= BASE+SIZE. Otherwise no memory read is issued and the channel's registers other than source are unchanged.
- R8: After its descriptor step, an enabled channel pulses `berr_evt` with `evt_ch` equal to its index when its source is zero, below BASE or above BASE+SIZE. A source equal to BASE+SIZE is accepted.
- R9: Channels are handled in ascending index order, one fetch at a time. `done` pulses for one cycle after the last channel. A `frame_start` that arrives while a frame is in progress is ignored.
- R10: While `mem_rd_valid` is high and `mem_rd_ready` is low, the address stays stable. A word is taken only in a cycle where both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Start-of-frame pulse |
| ch_en | input | NCH | Per-channel enable |
| wr_en | input | 1 | Register write strobe |
| wr_branch | input | 1 | 1: write branch register, 0: write next pointer |
| wr_ch | input | CW | Channel being written |
| wr_data | input | 32 | Write data |
| rd_ch | input | CW | Channel being read |
| rd_sel | input | 3 | 0 next, 1 source, 2 frame ID, 3 command, 4 branch |
| rd_data | output | 32 | Selected register value |
| mem_rd_valid | output | 1 | Memory read request valid |
| mem_rd_addr | output | 32 | Memory read word address |
| mem_rd_ready | input | 1 | Memory accepts request, data valid this cycle |
| mem_rd_data | input | 32 | Memory read data |
| branch_evt | output | 1 | Branch event pulse |
| berr_evt | output | 1 | Bus-error event pulse |
| evt_ch | output | CW | Channel of the latest event |
| done | output | 1 | Frame descriptor pass complete |

## Verification
A register write is visible on `rd_data` from the clock edge that takes it, so the bench reads back during the low phase of the next cycle. Events are registered pulses: `branch_evt` comes one cycle after a channel is selected, and `berr_evt` comes one cycle after its last descriptor beat. `done` rises with or after the last channel's event. The bench records every handshake beat and event at the falling edge while it drives ready with stalls. It waits for the done pulse, then compares register contents, beat addresses in order, and event counts against values worked out from the requirements. For the ignored second frame start it keeps watching for twenty more cycles.

// File: rtl/fdesc_pkg.sv
package fdesc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PICK  = 2'd1,
        ST_FETCH = 2'd2,
        ST_CHECK = 2'd3
    } seq_st_e;

    localparam int DESC_WORDS = 4;
    localparam int W_NEXT = 0;
    localparam int W_SRC  = 1;
    localparam int W_ID   = 2;
    localparam int W_CMD  = 3;
    localparam logic [2:0] SEL_BRANCH = 3'd4;

    localparam int BR_ACT = 0;
    localparam int BR_INT = 1;
    localparam logic [31:0] BR_MASK   = 32'hFFFF_FFF3;
    localparam logic [31:0] ADDR_MASK = 32'hFFFF_FFF0;
endpackage

// File: rtl/fdesc_win_chk.sv
module fdesc_win_chk #(
    parameter logic [31:0] BASE = 32'hA000_0000,
    parameter logic [31:0] SIZE = 32'h0001_0000,
    parameter int          SPAN = 16
) (
    input  logic [31:0] addr,
    output logic        ok
);
    localparam logic [32:0] LO = {1'b0, BASE};
    localparam logic [32:0] HI = {1'b0, BASE} + {1'b0, SIZE};

    always_comb begin
        ok = ({1'b0, addr} >= LO) && (({1'b0, addr} + 33'(SPAN)) <= HI);
    end
endmodule

// File: rtl/fdesc_rd_mux.sv
module fdesc_rd_mux
    import fdesc_pkg::*;
#(
    parameter int NCH = 7,
    parameter int CW  = $clog2(NCH)
) (
    input  logic [NCH-1:0][DESC_WORDS-1:0][31:0] dsc,
    input  logic [NCH-1:0][31:0]                 br,
    input  logic [CW-1:0]                        ch,
    input  logic [2:0]                           sel,
    output logic [31:0]                          data
);
    always_comb begin
        data = '0;
        for (int c = 0; c < NCH; c++) begin
            if (ch == CW'(c)) begin
                if (sel == SEL_BRANCH) begin
                    data = br[c];
                end else if (sel < 3'(DESC_WORDS)) begin
                    data = dsc[c][sel[1:0]];
                end
            end
        end
    end
endmodule

// File: rtl/fdesc_fetch.sv
module fdesc_fetch
    import fdesc_pkg::*;
#(
    parameter int          NCH      = 7,
    parameter logic [31:0] WIN_BASE = 32'hA000_0000,
    parameter logic [31:0] WIN_SIZE = 32'h0001_0000,
    localparam int         CW       = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_start,
    input  logic [NCH-1:0] ch_en,
    input  logic           wr_en,
    input  logic           wr_branch,
    input  logic [CW-1:0]  wr_ch,
    input  logic [31:0]    wr_data,
    input  logic [CW-1:0]  rd_ch,
    input  logic [2:0]     rd_sel,
    output logic [31:0]    rd_data,
    output logic           mem_rd_valid,
    output logic [31:0]    mem_rd_addr,
    input  logic           mem_rd_ready,
    input  logic [31:0]    mem_rd_data,
    output logic           branch_evt,
    output logic           berr_evt,
    output logic [CW-1:0]  evt_ch,
    output logic           done
);
    localparam int BW = $clog2(DESC_WORDS);

    typedef struct packed {
        seq_st_e                             st;
        logic [CW-1:0]                       ch;
        logic [BW-1:0]                       beat;
        logic [31:0]                         faddr;
        logic [NCH-1:0][DESC_WORDS-1:0][31:0] dsc;
        logic [NCH-1:0][31:0]                br;
        logic                                bevt;
        logic                                eevt;
        logic                                done;
        logic [CW-1:0]                       ech;
    } state_t;

    state_t q, d;

    logic [31:0] cur_next, cur_src, cur_br, pick_addr;
    logic        cur_en, desc_ok, src_ok, advance;

    // Current channel's registers, selected without out-of-range indexing
    always_comb begin
        cur_next = '0;
        cur_src  = '0;
        cur_br   = '0;
        cur_en   = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            if (q.ch == CW'(c)) begin
                cur_next = q.dsc[c][W_NEXT];
                cur_src  = q.dsc[c][W_SRC];
                cur_br   = q.br[c];
                cur_en   = ch_en[c];
            end
        end
        pick_addr = cur_br[BR_ACT] ? (cur_br & ADDR_MASK) : (cur_next & ADDR_MASK);
    end

    fdesc_win_chk #(.BASE(WIN_BASE), .SIZE(WIN_SIZE), .SPAN(4 * DESC_WORDS)) u_desc_win (
        .addr (pick_addr),
        .ok   (desc_ok)
    );

    fdesc_win_chk #(.BASE(WIN_BASE), .SIZE(WIN_SIZE), .SPAN(0)) u_src_win (
        .addr (cur_src),
        .ok   (src_ok)
    );

    fdesc_rd_mux #(.NCH(NCH), .CW(CW)) u_rd_mux (
        .dsc  (q.dsc),
        .br   (q.br),
        .ch   (rd_ch),
        .sel  (rd_sel),
        .data (rd_data)
    );

    always_comb begin
        d       = q;
        d.bevt  = 1'b0;
        d.eevt  = 1'b0;
        d.done  = 1'b0;
        advance = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (frame_start) begin
                    for (int c = 0; c < NCH; c++) d.dsc[c][W_SRC] = '0;
                    d.ch = '0;
                    d.st = ST_PICK;
                end
            end
            ST_PICK: begin
                if (!cur_en) begin
                    advance = 1'b1;
                end else begin
                    if (cur_br[BR_ACT]) begin
                        for (int c = 0; c < NCH; c++)
                            if (q.ch == CW'(c)) d.br[c][BR_ACT] = 1'b0;
                        d.bevt = cur_br[BR_INT];
                        d.ech  = q.ch;
                    end
                    if (desc_ok) begin
                        d.faddr = pick_addr;
                        d.beat  = '0;
                        d.st    = ST_FETCH;
                    end else begin
                        d.st = ST_CHECK;
                    end
                end
            end
            ST_FETCH: begin
                if (mem_rd_ready) begin
                    for (int c = 0; c < NCH; c++)
                        if (q.ch == CW'(c)) d.dsc[c][q.beat] = mem_rd_data;
                    if (q.beat == BW'(DESC_WORDS - 1)) d.st = ST_CHECK;
                    else d.beat = q.beat + 1'b1;
                end
            end
            ST_CHECK: begin
                if ((cur_src == '0) || !src_ok) begin
                    d.eevt = 1'b1;
                    d.ech  = q.ch;
                end
                advance = 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase

        if (advance) begin
            if (q.ch == CW'(NCH - 1)) begin
                d.done = 1'b1;
                d.st   = ST_IDLE;
            end else begin
                d.ch = q.ch + 1'b1;
                d.st = ST_PICK;
            end
        end

        // Software writes take precedence over sequencer updates
        if (wr_en) begin
            for (int c = 0; c < NCH; c++) begin
                if (wr_ch == CW'(c)) begin
                    if (wr_branch) d.br[c] = wr_data & BR_MASK;
                    else d.dsc[c][W_NEXT] = wr_data & ADDR_MASK;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else q <= d;
    end

    assign mem_rd_valid = (q.st == ST_FETCH);
    assign mem_rd_addr  = q.faddr + {{(30-BW){1'b0}}, q.beat, 2'b00};
    assign branch_evt   = q.bevt;
    assign berr_evt     = q.eevt;
    assign evt_ch       = q.ech;
    assign done         = q.done;
endmodule

// File: rtl/fdesc_fetch_chk.sv
module fdesc_fetch_chk #(
    parameter int          NCH      = 7,
    parameter logic [31:0] WIN_BASE = 32'hA000_0000,
    parameter logic [31:0] WIN_SIZE = 32'h0001_0000,
    localparam int         CW       = $clog2(NCH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_rd_valid,
    input logic [31:0]   mem_rd_addr,
    input logic          mem_rd_ready,
    input logic          branch_evt,
    input logic          berr_evt,
    input logic [CW-1:0] evt_ch,
    input logic          done
);
    localparam logic [32:0] HI = {1'b0, WIN_BASE} + {1'b0, WIN_SIZE};

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr))); // R10

    AST_DESC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_valid) |-> (mem_rd_addr[3:0] == 4'h0)); // R4

    AST_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> (({1'b0, mem_rd_addr} >= {1'b0, WIN_BASE}) &&
                          ({1'b0, mem_rd_addr} + 33'd4 <= HI))); // R7

    AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({branch_evt, berr_evt})); // R5

    AST_EVT_CH: assert property (@(posedge clk) disable iff (!rst_n)
        (branch_evt || berr_evt) |-> (32'(evt_ch) < NCH)); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_NO_READ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_rd_valid); // R9
endmodule

bind fdesc_fetch fdesc_fetch_chk #(.NCH(NCH), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)) u_chk (.*);

// File: tb/tb_fdesc_fetch.sv
`timescale 1ns/1ps
module tb_fdesc_fetch;
    localparam int NCH = 7;
    localparam int CW  = 3;
    localparam logic [31:0] BASE = 32'hA000_0000;
    localparam logic [31:0] SIZE = 32'h0001_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0;
    logic [NCH-1:0] ch_en = '0;
    logic wr_en = 1'b0, wr_branch = 1'b0;
    logic [CW-1:0] wr_ch = '0, rd_ch = '0;
    logic [31:0] wr_data = '0;
    logic [2:0] rd_sel = '0;
    logic [31:0] rd_data, mem_rd_addr, mem_rd_data;
    logic mem_rd_valid, mem_rd_ready, branch_evt, berr_evt, done;
    logic [CW-1:0] evt_ch;

    logic [31:0] mem [0:1023];
    assign mem_rd_data = mem[mem_rd_addr[11:2]];

    always #2.5 clk = ~clk;

    fdesc_fetch #(.NCH(NCH), .WIN_BASE(BASE), .WIN_SIZE(SIZE)) dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .ch_en(ch_en),
        .wr_en(wr_en), .wr_branch(wr_branch), .wr_ch(wr_ch), .wr_data(wr_data),
        .rd_ch(rd_ch), .rd_sel(rd_sel), .rd_data(rd_data),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ready(mem_rd_ready), .mem_rd_data(mem_rd_data),
        .branch_evt(branch_evt), .berr_evt(berr_evt), .evt_ch(evt_ch), .done(done)
    );

    // Monitor and ready driver: one process owns these
    logic stall = 1'b0;
    int cyc = 0, rd_total = 0, bevt_total = 0, berr_total = 0, done_total = 0;
    int bevt_last = 0, berr_last = 0;
    logic [31:0] rd_log [0:255];
    logic rdy_q = 1'b0;
    assign mem_rd_ready = rdy_q;

    always @(negedge clk) begin
        cyc = cyc + 1;
        rdy_q = stall ? ((cyc % 3) == 0) : 1'b1;
        if (mem_rd_valid && rdy_q) begin
            rd_log[rd_total % 256] = mem_rd_addr;
            rd_total = rd_total + 1;
        end
        if (branch_evt) begin bevt_total = bevt_total + 1; bevt_last = int'(evt_ch); end
        if (berr_evt) begin berr_total = berr_total + 1; berr_last = int'(evt_ch); end
        if (done) done_total = done_total + 1;
    end

    int nchk = 0, nfail = 0;
    int s_rd, s_bevt, s_berr, s_done;
    logic [31:0] v, keep;
    bit wd = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic br, input int ch, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_branch = br; wr_ch = CW'(ch); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_reg(input int ch, input int sel, output logic [31:0] val);
        @(negedge clk);
        rd_ch = CW'(ch); rd_sel = 3'(sel);
        #1 val = rd_data;
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] nx, input logic [31:0] src,
                            input logic [31:0] id, input logic [31:0] cmd);
        mem[a[11:2]]     = nx;
        mem[a[11:2] + 1] = src;
        mem[a[11:2] + 2] = id;
        mem[a[11:2] + 3] = cmd;
    endtask

    task automatic run_frame(input logic [NCH-1:0] en, input bit again);
        @(negedge clk);
        s_rd = rd_total; s_bevt = bevt_total; s_berr = berr_total; s_done = done_total;
        ch_en = en; frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        if (again) begin
            repeat (3) @(negedge clk);
            frame_start = 1'b1;
            @(negedge clk);
            frame_start = 1'b0;
        end
        for (int k = 0; k < 400 && done_total == s_done; k++) @(negedge clk);
        repeat (2) @(negedge clk);
        if (done_total == s_done) check("R9 frame completes", 32'd0, 32'd1);
    endtask

    task automatic t_reset();
        check("R1 valid low", 32'(mem_rd_valid), 0);
        check("R1 done low", 32'(done), 0);
        check("R1 events low", 32'({branch_evt, berr_evt}), 0);
        for (int s = 0; s < 5; s++) begin
            rd_reg(0, s, v);
            check("R1 ch0 register zero", v, 0);
        end
        rd_reg(6, 4, v); check("R1 ch6 branch zero", v, 0);
    endtask

    task automatic t_masks();
        wr_reg(1'b0, 2, 32'hA000_0127);
        rd_reg(2, 0, v); check("R2 next pointer masked", v, 32'hA000_0120);
        wr_reg(1'b1, 4, 32'hFFFF_FFFF);
        rd_reg(4, 4, v); check("R3 branch masked", v, 32'hFFFF_FFF3);
        wr_reg(1'b1, 4, 32'h0);
    endtask

    task automatic t_chain();
        put_desc(BASE + 32'h100, BASE + 32'h200, BASE + 32'h1000, 32'h11, 32'h0060_0040);
        put_desc(BASE + 32'h200, BASE + 32'h100, BASE + 32'h2000, 32'h22, 32'h4);
        wr_reg(1'b0, 0, BASE + 32'h100);
        stall = 1'b1;
        run_frame(7'b000_0001, 1'b0);
        check("R4 beat count", 32'(rd_total - s_rd), 4);
        for (int k = 0; k < 4; k++)
            check("R4 beat address", rd_log[(s_rd + k) % 256], BASE + 32'h100 + 32'(4 * k));
        rd_reg(0, 0, v); check("R4 next loaded", v, BASE + 32'h200);
        rd_reg(0, 1, v); check("R10 source loaded under stalls", v, BASE + 32'h1000);
        rd_reg(0, 2, v); check("R4 id loaded", v, 32'h11);
        rd_reg(0, 3, v); check("R4 command loaded", v, 32'h0060_0040);
        check("R8 no bus error on valid source", 32'(berr_total - s_berr), 0);
        run_frame(7'b000_0001, 1'b0);
        check("R4 chained fetch address", rd_log[s_rd % 256], BASE + 32'h200);
        rd_reg(0, 2, v); check("R4 chained id", v, 32'h22);
        stall = 1'b0;
    endtask

    task automatic t_branch();
        put_desc(BASE + 32'h300, BASE + 32'h300, BASE + 32'h3000, 32'h33, 32'h0);
        put_desc(BASE + 32'h400, BASE + 32'h300, BASE + 32'h4000, 32'h44, 32'h0);
        put_desc(BASE + 32'h500, BASE + 32'h300, BASE + 32'h5000, 32'h55, 32'h0);
        wr_reg(1'b0, 1, BASE + 32'h300);
        wr_reg(1'b1, 1, BASE + 32'h403);
        run_frame(7'b000_0011, 1'b0);
        check("R5 one branch event", 32'(bevt_total - s_bevt), 1);
        check("R5 branch event channel", 32'(bevt_last), 1);
        rd_reg(1, 4, v); check("R5 active bit cleared", v, BASE + 32'h402);
        rd_reg(1, 2, v); check("R5 fetched from branch", v, 32'h44);
        check("R9 ch0 before ch1", rd_log[s_rd % 256], BASE + 32'h100);
        check("R9 ch1 after ch0", rd_log[(s_rd + 4) % 256], BASE + 32'h400);
        run_frame(7'b000_0011, 1'b0);
        check("R5 no event without active", 32'(bevt_total - s_bevt), 0);
        rd_reg(1, 2, v); check("R5 back to chain", v, 32'h33);
        wr_reg(1'b1, 1, BASE + 32'h501);
        run_frame(7'b000_0011, 1'b0);
        check("R5 no event when interrupt bit clear", 32'(bevt_total - s_bevt), 0);
        rd_reg(1, 2, v); check("R5 silent branch taken", v, 32'h55);
        rd_reg(1, 4, v); check("R5 silent branch cleared", v, BASE + 32'h500);
    endtask

    task automatic t_disabled();
        put_desc(BASE + 32'h600, BASE + 32'h600, BASE + 32'h6000, 32'h66, 32'h0);
        wr_reg(1'b0, 3, BASE + 32'h600);
        rd_reg(0, 2, keep);
        run_frame(7'b000_0010, 1'b0);
        rd_reg(0, 1, v); check("R6 disabled source cleared", v, 0);
        rd_reg(0, 2, v); check("R6 disabled id kept", v, keep);
        rd_reg(3, 2, v); check("R6 disabled ch3 not fetched", v, 0);
        check("R6 only ch1 fetched", 32'(rd_total - s_rd), 4);
        check("R6 ch1 address", rd_log[s_rd % 256], BASE + 32'h300);
        check("R6 no event from disabled", 32'(berr_total - s_berr), 0);
    endtask

    task automatic t_window();
        wr_reg(1'b0, 2, 32'h0000_0100);
        run_frame(7'b000_0100, 1'b0);
        check("R7 below window no read", 32'(rd_total - s_rd), 0);
        check("R7 below window bus error", 32'(berr_total - s_berr), 1);
        check("R8 bus error channel", 32'(berr_last), 2);
        rd_reg(2, 2, v); check("R7 id unchanged", v, 0);
        put_desc(BASE + SIZE - 32'h10, BASE + 32'h700, BASE + 32'h7000, 32'h77, 32'h0);
        wr_reg(1'b0, 2, BASE + SIZE - 32'h10);
        run_frame(7'b000_0100, 1'b0);
        check("R7 last slot fetched", 32'(rd_total - s_rd), 4);
        rd_reg(2, 2, v); check("R7 last slot id", v, 32'h77);
        wr_reg(1'b0, 2, BASE + SIZE);
        run_frame(7'b000_0100, 1'b0);
        check("R7 past window no read", 32'(rd_total - s_rd), 0);
        rd_reg(2, 2, v); check("R7 past window id kept", v, 32'h77);
    endtask

    task automatic t_source();
        put_desc(BASE + 32'h700, BASE + 32'h700, 32'h0, 32'h70, 32'h0);
        put_desc(BASE + 32'h710, BASE + 32'h710, BASE + SIZE, 32'h71, 32'h0);
        put_desc(BASE + 32'h720, BASE + 32'h720, BASE + SIZE + 32'h4, 32'h72, 32'h0);
        put_desc(BASE + 32'h730, BASE + 32'h730, BASE - 32'h4, 32'h73, 32'h0);
        wr_reg(1'b0, 2, BASE + 32'h700);
        run_frame(7'b000_0100, 1'b0);
        check("R8 zero source error", 32'(berr_total - s_berr), 1);
        wr_reg(1'b0, 2, BASE + 32'h710);
        run_frame(7'b000_0100, 1'b0);
        check("R8 top edge source accepted", 32'(berr_total - s_berr), 0);
        wr_reg(1'b0, 2, BASE + 32'h720);
        run_frame(7'b000_0100, 1'b0);
        check("R8 above window error", 32'(berr_total - s_berr), 1);
        wr_reg(1'b0, 2, BASE + 32'h730);
        run_frame(7'b000_0100, 1'b0);
        check("R8 below window error", 32'(berr_total - s_berr), 1);
        rd_reg(2, 2, v); check("R8 descriptor still loaded", v, 32'h73);
    endtask

    task automatic t_order();
        wr_reg(1'b0, 0, BASE + 32'h100);
        wr_reg(1'b0, 1, BASE + 32'h300);
        wr_reg(1'b0, 2, BASE + 32'h200);
        run_frame(7'b000_0111, 1'b1);
        repeat (20) @(negedge clk);
        check("R9 twelve beats", 32'(rd_total - s_rd), 12);
        check("R9 first ch0", rd_log[s_rd % 256], BASE + 32'h100);
        check("R9 then ch1", rd_log[(s_rd + 4) % 256], BASE + 32'h300);
        check("R9 then ch2", rd_log[(s_rd + 8) % 256], BASE + 32'h200);
        check("R9 single done, busy start ignored", 32'(done_total - s_done), 1);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        fork
            begin
                repeat (4) @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_masks();
                t_chain();
                t_branch();
                t_disabled();
                t_window();
                t_source();
                t_order();
            end
            begin
                repeat (150000) @(posedge clk);
                wd = 1'b1;
            end
        join_any
        disable fork;
        if (wd) begin
            nchk++; nfail++;
            $display("FAIL R9 watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule